// File: doc/BRIEF.md
# Serial Flash Range Erase Sequencer

This block erases a byte range on a serial flash that is organised in pages whose size need not be a power of two. A host gives a start address and a length, both in bytes, plus the page geometry: the page size, the left shift that turns a page index into a device address, and the device size in pages. The block first checks the request. It then walks the range one erase step at a time. Each step is either an eight-page block erase or a single-page erase.

Every step sends a four-byte command frame through a byte-wide port to an external serial shifter, which owns chip select. The block then polls the device status until the device reports ready, and only then starts the next step. When no pages remain, a one-cycle done pulse ends the operation. Done also ends the operation when the request is rejected or when polling gives up.

Top module: `flash_erase_seq`

## Requirements
- R1: A request is rejected when the start address or the length is not a whole multiple of the page size, or when start plus length exceeds page size times device pages. A rejected request ends with range_err_o set and sends no frame at all.
- R2: The page index is the byte address divided by the page size. The device address is that index shifted left by the geometry shift. An erase frame is four bytes: opcode, device address bits [23:16], device address bits [15:8], then 0x00.
- R3: A step uses block erase (opcode 0x50) when the current page index is a multiple of eight and at least eight pages remain. Otherwise it uses page erase (opcode 0x81).
- R4: After a block erase the page index advances by eight and the remaining count drops by eight. After a page erase both change by one. The number of erase frames matches this walk.
- R5: After each erase frame the block sends two-byte status frames (0xD7, 0x00). It reads the byte received with the second byte as ready only when bit 7 is set and the byte is not all ones. It repeats until ready before the next erase frame. Chip select is deasserted between frames.
- R6: If POLL_LIMIT consecutive status reads in one step report not-ready, the operation stops with timeout_err_o set.
- R7: busy_o is high from the cycle after an accepted start until the operation ends. done_o is a one-cycle pulse, and busy_o is low during that pulse.
- R8: A start pulse that arrives while busy_o is high, or in the cycle that done_o is high, is ignored. It does not change the frames sent and starts no new operation.
- R9: A zero length is accepted. The operation ends with done_o, sends no frame and sets no error.
- R10: byte_req_o stays high with byte_tx_o unchanged until byte_ack_i. While idle, chip select is high and no byte is requested.
- R11: Both error flags hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| addr_i | input | ADDR_W | Byte start address |
| len_i | input | ADDR_W | Byte length |
| page_size_i | input | PS_W | Bytes per page |
| page_shift_i | input | SH_W | Page index shift into the device address |
| dev_pages_i | input | PG_W | Device size in pages |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| range_err_o | output | 1 | Request rejected |
| timeout_err_o | output | 1 | Status polling gave up |
| cs_n_o | output | 1 | Chip select to the shifter, low during a frame |
| byte_req_o | output | 1 | Byte transfer request |
| byte_tx_o | output | 8 | Byte to send |
| byte_ack_i | input | 1 | Byte transfer complete |
| byte_rx_i | input | 8 | Byte received during the acknowledged transfer |

## Verification
Two events can fall in the same cycle: a new start request, and the done pulse of the operation still ending. The bench raises start exactly in the cycle it first sees done high. It then checks that busy stays low and that no frame follows. It also injects a start with different arguments in the middle of an erase. The frame stream must still match the reference walk of the first request only. A behavioural device model answers the byte port with varying latency and a configurable busy time. It compares every erase frame against a queue built from the requirements. It also counts the status frames between erase frames.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam int BLOCK_PAGES   = 8;
  localparam int BLOCK_ALIGN_W = $clog2(BLOCK_PAGES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_CHECK, ST_STEP, ST_CMD, ST_GAP, ST_POLL, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/erase_pgdiv.sv
module erase_pgdiv #(
  parameter int DW = 24,
  parameter int VW = 11,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  input  logic [QW-1:0] limit_i,
  output logic          fin_o,
  output logic [QW:0]   quot_o,
  output logic          inexact_o,
  output logic          over_o
);
  logic          run_q, run_d;
  logic [DW-1:0] rem_q, rem_d;
  logic [VW-1:0] dvs_q;
  logic [QW-1:0] lim_q;
  logic [QW:0]   quot_q, quot_d;
  logic          over, fits;

  assign over = quot_q > {1'b0, lim_q};
  assign fits = rem_q >= DW'(dvs_q);

  always_comb begin
    run_d  = run_q;
    rem_d  = rem_q;
    quot_d = quot_q;
    if (load_i) begin
      run_d  = 1'b1;
      rem_d  = dividend_i;
      quot_d = '0;
    end else if (run_q) begin
      if (over || !fits) begin
        run_d = 1'b0;
      end else begin
        rem_d  = rem_q - DW'(dvs_q);
        quot_d = quot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rem_q  <= '0;
      quot_q <= '0;
    end else begin
      run_q  <= run_d;
      rem_q  <= rem_d;
      quot_q <= quot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      dvs_q <= divisor_i;
      lim_q <= limit_i;
    end
  end

  assign fin_o     = !run_q;
  assign quot_o    = quot_q;
  assign inexact_o = rem_q != '0;
  assign over_o    = over;

  // R1: the quotient search stops one past the device size
  p_quot_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (quot_q <= ({1'b0, lim_q} + 1'b1)));
endmodule

// File: rtl/erase_step_pick.sv
module erase_step_pick
  import flash_erase_pkg::*;
#(
  parameter int PG_W = 16,
  parameter int SH_W = 4
) (
  input  logic [PG_W-1:0] pg_i,
  input  logic [PG_W-1:0] rem_i,
  input  logic [SH_W-1:0] shift_i,
  output logic [7:0]      opcode_o,
  output logic [15:0]     dev_hi_o,
  output logic [PG_W-1:0] step_o
);
  localparam int WIDE_W = PG_W + (1 << SH_W);
  logic use_block;

  assign use_block = (pg_i[BLOCK_ALIGN_W-1:0] == '0) &&
                     (rem_i >= PG_W'(BLOCK_PAGES));
  assign opcode_o  = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
  assign step_o    = use_block ? PG_W'(BLOCK_PAGES) : PG_W'(1);
  assign dev_hi_o  = 16'((WIDE_W'(pg_i) << shift_i) >> 8);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PS_W       = 11,
  parameter int SH_W       = 4,
  parameter int PG_W       = 16,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [PS_W-1:0]   page_size_i,
  input  logic [SH_W-1:0]   page_shift_i,
  input  logic [PG_W-1:0]   dev_pages_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              range_err_o,
  output logic              timeout_err_o,
  output logic              cs_n_o,
  output logic              byte_req_o,
  output logic [7:0]        byte_tx_o,
  input  logic              byte_ack_i,
  input  logic [7:0]        byte_rx_i
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e        state_q, state_d;
  logic [PG_W-1:0]   pg_q, pg_d, rem_q, rem_d, pages_q;
  logic [SH_W-1:0]   sh_q;
  logic [1:0]        bidx_q, bidx_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  logic [7:0]        op_q;
  logic [15:0]       dhi_q;
  logic              rerr_q, rerr_d, terr_q, terr_d;
  logic              accept, ld_step, range_bad, dev_ready;

  logic            a_fin, a_inx, a_over, l_fin, l_inx, l_over;
  logic [PG_W:0]   a_q, l_q;
  logic [7:0]      p_op;
  logic [15:0]     p_dhi;
  logic [PG_W-1:0] p_step;

  assign accept = (state_q == ST_IDLE) && start_i;

  erase_pgdiv #(.DW(ADDR_W), .VW(PS_W), .QW(PG_W)) u_div_addr (
    .clk(clk), .rst_n(rst_sync_n), .load_i(accept), .dividend_i(addr_i),
    .divisor_i(page_size_i), .limit_i(dev_pages_i), .fin_o(a_fin),
    .quot_o(a_q), .inexact_o(a_inx), .over_o(a_over));

  erase_pgdiv #(.DW(ADDR_W), .VW(PS_W), .QW(PG_W)) u_div_len (
    .clk(clk), .rst_n(rst_sync_n), .load_i(accept), .dividend_i(len_i),
    .divisor_i(page_size_i), .limit_i(dev_pages_i), .fin_o(l_fin),
    .quot_o(l_q), .inexact_o(l_inx), .over_o(l_over));

  erase_step_pick #(.PG_W(PG_W), .SH_W(SH_W)) u_pick (
    .pg_i(pg_q), .rem_i(rem_q), .shift_i(sh_q),
    .opcode_o(p_op), .dev_hi_o(p_dhi), .step_o(p_step));

  assign range_bad = a_inx || l_inx || a_over || l_over ||
                     (({1'b0, a_q} + {1'b0, l_q}) > (PG_W+2)'(pages_q));
  assign dev_ready = byte_rx_i[7] && (byte_rx_i != 8'hFF);

  always_comb begin
    state_d = state_q;
    pg_d    = pg_q;
    rem_d   = rem_q;
    bidx_d  = bidx_q;
    polls_d = polls_q;
    rerr_d  = rerr_q;
    terr_d  = terr_q;
    ld_step = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_DIV;
        rerr_d  = 1'b0;
        terr_d  = 1'b0;
      end
      ST_DIV: if (a_fin && l_fin) state_d = ST_CHECK;
      ST_CHECK: if (range_bad) begin
        rerr_d  = 1'b1;
        state_d = ST_FIN;
      end else begin
        pg_d    = a_q[PG_W-1:0];
        rem_d   = l_q[PG_W-1:0];
        state_d = ST_STEP;
      end
      ST_STEP: if (rem_q == '0) begin
        state_d = ST_FIN;
      end else begin
        ld_step = 1'b1;
        bidx_d  = 2'd0;
        polls_d = '0;
        state_d = ST_CMD;
      end
      ST_CMD: if (byte_ack_i) begin
        if (bidx_q == 2'd3) state_d = ST_GAP;
        else                bidx_d  = bidx_q + 2'd1;
      end
      ST_GAP: begin
        bidx_d  = 2'd0;
        state_d = ST_POLL;
      end
      ST_POLL: if (byte_ack_i) begin
        if (bidx_q == 2'd0) begin
          bidx_d = 2'd1;
        end else if (dev_ready) begin
          pg_d    = pg_q + p_step;
          rem_d   = rem_q - p_step;
          state_d = ST_STEP;
        end else if (polls_q == POLL_W'(POLL_LIMIT - 1)) begin
          terr_d  = 1'b1;
          state_d = ST_FIN;
        end else begin
          polls_d = polls_q + 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pg_q    <= '0;
      rem_q   <= '0;
      bidx_q  <= '0;
      polls_q <= '0;
      rerr_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pg_q    <= pg_d;
      rem_q   <= rem_d;
      bidx_q  <= bidx_d;
      polls_q <= polls_d;
      rerr_q  <= rerr_d;
      terr_q  <= terr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pages_q <= '0;
      sh_q    <= '0;
    end else if (accept) begin
      pages_q <= dev_pages_i;
      sh_q    <= page_shift_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q  <= '0;
      dhi_q <= '0;
    end else if (ld_step) begin
      op_q  <= p_op;
      dhi_q <= p_dhi;
    end
  end

  always_comb begin
    byte_tx_o = 8'h00;
    if (state_q == ST_CMD) begin
      unique case (bidx_q)
        2'd0:    byte_tx_o = op_q;
        2'd1:    byte_tx_o = dhi_q[15:8];
        2'd2:    byte_tx_o = dhi_q[7:0];
        default: byte_tx_o = 8'h00;
      endcase
    end else if (state_q == ST_POLL) begin
      byte_tx_o = (bidx_q == 2'd0) ? OP_STATUS : 8'h00;
    end
  end

  assign byte_req_o    = (state_q == ST_CMD) || (state_q == ST_POLL);
  assign cs_n_o        = !byte_req_o;
  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done_o        = state_q == ST_FIN;
  assign range_err_o   = rerr_q;
  assign timeout_err_o = terr_q;

  // R10: a requested byte is held until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (byte_req_o && !byte_ack_i) |=> (byte_req_o && $stable(byte_tx_o)));
  // R7: done lasts one cycle and is followed by idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> (!done_o && !busy_o));
  // R3: a block frame only goes out on an aligned index with eight pages left
  p_block_align_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_CMD && op_q == OP_BLOCK_ERASE) |->
      (pg_q[BLOCK_ALIGN_W-1:0] == '0 && rem_q >= PG_W'(BLOCK_PAGES)));
  // R4: outside the load, the remaining count only shrinks
  p_rem_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(state_q) != ST_CHECK && !$stable(rem_q)) |-> (rem_q < $past(rem_q)));
  // R1: a rejected request keeps chip select high
  p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    range_err_o |-> cs_n_o);
  // R8: start during the done cycle leads back to idle
  p_fin_start_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && start_i) |=> !busy_o);
endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 6;

  logic        clk, rst_n, start_i;
  logic [23:0] addr_i, len_i;
  logic [10:0] page_size_i;
  logic [3:0]  page_shift_i;
  logic [15:0] dev_pages_i;
  logic        busy_o, done_o, range_err_o, timeout_err_o;
  logic        cs_n_o, byte_req_o, byte_ack_i;
  logic [7:0]  byte_tx_o, byte_rx_i;

  flash_erase_seq #(.POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .len_i(len_i), .page_size_i(page_size_i), .page_shift_i(page_shift_i),
    .dev_pages_i(dev_pages_i), .busy_o(busy_o), .done_o(done_o),
    .range_err_o(range_err_o), .timeout_err_o(timeout_err_o),
    .cs_n_o(cs_n_o), .byte_req_o(byte_req_o), .byte_tx_o(byte_tx_o),
    .byte_ack_i(byte_ack_i), .byte_rx_i(byte_rx_i));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nfail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] fb[0:7];
  int nb, dcnt, ack_dly = 1, busy_len = 0, dev_busy = 0;
  int n_erase, n_poll, polls_since;
  bit prev_cs, ff_mode = 0, first_frame;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic end_frame();
    if (nb == 2 && fb[0] == 8'hD7) begin
      chk(fb[1] == 8'h00, "R5 status frame dummy byte", fb[1], 0);
      n_poll++;
      polls_since++;
      if (dev_busy > 0) dev_busy--;
    end else if (nb == 4) begin
      if (!first_frame)
        chk(polls_since == busy_len + 1, "R5 polls between erase frames", polls_since, busy_len + 1);
      first_frame = 0;
      polls_since = 0;
      n_erase++;
      dev_busy = busy_len;
      if (exp_q.size() < 4) begin
        chk(0, "R2 R3 unexpected erase frame", fb[0], 0);
      end else begin
        for (int i = 0; i < 4; i++) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(fb[i] == e, "R2 R3 erase frame byte", fb[i], e);
        end
      end
    end else begin
      chk(0, "R5 frame length", nb, 4);
    end
  endtask

  // device model on the byte port, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      byte_ack_i = 1'b0;
      byte_rx_i  = 8'h00;
      dcnt = 0;
      nb = 0;
      prev_cs = 1'b1;
    end else begin
      if (!busy_o)
        chk(cs_n_o && !byte_req_o, "R10 bus quiet while idle", cs_n_o, 1);
      if (prev_cs && !cs_n_o) nb = 0;
      if (!prev_cs && cs_n_o) end_frame();
      prev_cs = cs_n_o;
      if (byte_ack_i) begin
        byte_ack_i = 1'b0;
      end else if (byte_req_o) begin
        dcnt++;
        if (dcnt >= ack_dly) begin
          dcnt = 0;
          if (nb < 8) fb[nb] = byte_tx_o;
          if (nb == 1 && fb[0] == 8'hD7)
            byte_rx_i = ff_mode ? 8'hFF : ((dev_busy > 0) ? 8'h7F : 8'h80);
          else
            byte_rx_i = 8'h00;
          nb++;
          byte_ack_i = 1'b1;
        end
      end
    end
  end

  task automatic build_expect(input int a, input int l, input int ps, input int sh,
                              input int pages, output bit bad);
    int pg, rm, st, da;
    logic [7:0] op;
    exp_q.delete();
    bad = (ps == 0) || (a % ps != 0) || (l % ps != 0) || (a + l > pages * ps);
    if (!bad) begin
      pg = a / ps;
      rm = l / ps;
      while (rm > 0) begin
        if (pg % 8 == 0 && rm >= 8) begin op = 8'h50; st = 8; end
        else begin op = 8'h81; st = 1; end
        da = (pg << sh) & 24'hFFFFFF;
        exp_q.push_back(op);
        exp_q.push_back(8'((da >> 16) & 255));
        exp_q.push_back(8'((da >> 8) & 255));
        exp_q.push_back(8'h00);
        pg += st;
        rm -= st;
      end
    end
  endtask

  task automatic run_op(input int a, input int l, input int ps, input int sh,
                        input int pages, input int blen, input int ackd,
                        input bit exp_to, input bit inject, input bit coincide);
    bit bad, injected;
    int nfr, tail;
    build_expect(a, l, ps, sh, pages, bad);
    if (exp_to) while (exp_q.size() > 4) void'(exp_q.pop_back());
    nfr = exp_q.size() / 4;
    tail = exp_to ? LIMIT : blen + 1;
    n_erase = 0; n_poll = 0; polls_since = 0; first_frame = 1;
    busy_len = blen; ack_dly = ackd; injected = 0;
    @(negedge clk);
    addr_i = 24'(a); len_i = 24'(l); page_size_i = 11'(ps);
    page_shift_i = 4'(sh); dev_pages_i = 16'(pages);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after accepted start", busy_o, 1);
    while (!done_o) begin
      @(negedge clk);
      start_i = inject && !injected && n_erase == 1;
      if (start_i) begin
        injected = 1;
        addr_i = 24'(ps * 2); len_i = 24'(ps); page_shift_i = 4'd0;
      end
    end
    #(CLK_PERIOD/4);
    chk(busy_o == 1'b0, "R7 busy low during done", busy_o, 0);
    chk(range_err_o == bad, "R1 R11 range error flag", range_err_o, bad);
    chk(timeout_err_o == exp_to, "R6 R11 timeout flag", timeout_err_o, exp_to);
    chk(exp_q.size() == 0, "R2 R3 all expected frames sent", exp_q.size(), 0);
    chk(n_erase == nfr, "R4 erase frame count", n_erase, nfr);
    if (nfr > 0) chk(polls_since == tail, "R5 R6 polls after last erase", polls_since, tail);
    else         chk(n_poll == 0, "R1 R9 no status frames", n_poll, 0);
    if (coincide) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(!done_o && !busy_o, "R8 start during done ignored", busy_o, 0);
      @(negedge clk);
      chk(!busy_o && cs_n_o, "R8 no operation after ignored start", busy_o, 0);
    end else begin
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done is one cycle", done_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    addr_i = '0; len_i = '0; page_size_i = 11'd264; page_shift_i = 4'd9; dev_pages_i = 16'd64;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o, "R7 reset idle", busy_o, 0);
    chk(cs_n_o && !byte_req_o, "R10 reset bus quiet", cs_n_o, 1);
    chk(!range_err_o && !timeout_err_o, "R11 reset flags clear", range_err_o, 0);

    // R3 R4: two blocks then four pages
    run_op(0, 20*264, 264, 9, 64, 2, 1, 0, 0, 0);
    // R3: unaligned start, aligned index with fewer than eight left
    run_op(3*264, 12*264, 264, 9, 64, 0, 2, 0, 0, 0);
    // R8: start injected mid-operation, other geometry
    run_op(16*528, 8*528, 528, 10, 32, 1, 3, 0, 1, 0);
    // R1 boundary: exact fit accepted; R8 start coinciding with done
    run_op(56*264, 8*264, 264, 9, 64, 0, 1, 0, 0, 1);
    // R1: past the end, unaligned start, unaligned length
    run_op(60*264, 8*264, 264, 9, 64, 0, 1, 0, 0, 0);
    run_op(100, 264, 264, 9, 64, 0, 1, 0, 0, 0);
    run_op(264, 300, 264, 9, 64, 0, 1, 0, 0, 0);
    // R9 R11: zero length after an error
    run_op(5*264, 0, 264, 9, 64, 0, 1, 0, 0, 0);
    // R6: device never ready
    run_op(8*264, 9*264, 264, 9, 64, 100, 1, 1, 0, 0);
    // R5: all-ones status is not ready
    ff_mode = 1;
    run_op(264, 264, 264, 9, 64, 0, 2, 1, 0, 0);
    ff_mode = 0;
    // R2 R11: high address bits, large page
    run_op(150*1056, 3*1056, 1056, 11, 200, 1, 1, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule